// File: doc/BRIEF.md
# Left-Justified Stereo Audio Serial Transmitter

This block feeds an external stereo DAC codec. It takes 16-bit audio words from a show-ahead sample FIFO through a ready/valid read port and shifts them out MSB first on a single data line. It also produces the bit clock and the frame (left/right) clock that go with the data. Both clocks come from dividing the master clock that runs the block. The frame is left-justified: the MSB of each channel word appears in the same bit-clock period in which the frame clock changes level. The left word is carried while the frame clock is high and the right word while it is low.

A small host register port holds a configuration register and a status register. The configuration register has an enable bit and a rate code. Each step of the rate code doubles the sample rate, and the two default codes give a 2:1 pair such as 16 kHz and 32 kHz. A new rate takes effect only at the next frame boundary, so neither clock ever gets a shortened phase. The bit clock runs at 2 × SAMPLE_W times the frame rate. If the FIFO is empty when a channel word is due, that channel carries zeros and a sticky underrun flag is raised. The host can read the flag and clear it with a write.

Top module: `lj_audio_tx`

## Requirements
- R1: After reset, dac_bclk, dac_lrck, dac_sdata and smp_ready are 0, and both registers (address 0 = configuration, address 1 = status) read as 0.
- R2: While configuration bit 0 (enable) is 0, dac_bclk, dac_lrck and dac_sdata stay low from the cycle after it was cleared, and smp_ready stays low, so no sample is consumed.
- R3: With rate code c in configuration bits [RATE_W:1], each high phase and each low phase of dac_bclk lasts (HALF_MIN << (NUM_RATES-1)) >> c master-clock cycles. Code 0 is the slowest rate. The configuration register reads back as written.
- R4: A frame is 2 × SAMPLE_W bit-clock periods long, with exactly SAMPLE_W bits per channel.
- R5: dac_lrck is 1 for the left word and 0 for the right word. Each word is sent MSB first, with the MSB in the first bit period of its half and no one-bit delay.
- R6: dac_lrck and dac_sdata change only together with a falling edge of dac_bclk, so they are stable whenever dac_bclk is high.
- R7: Exactly one word is read per channel, at the falling edge that starts that channel. Words are used in FIFO order: left first, then right.
- R8: If smp_valid is 0 when a word is due, that channel sends all zeros and status bit 0 (underrun) is set. The bit stays set until the host clears it.
- R9: Writing 1 to status bit 0 clears the underrun flag. If a new underrun happens in the same cycle as the clearing write, the flag stays set.
- R10: A rate-code write made during a frame does not change that frame. The new half-period starts at the falling edge that begins the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all dividers count it |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_wr_addr | input | 1 | Write address: 0 configuration, 1 status |
| host_wr_data | input | HOST_DW | Write data |
| host_rd_addr | input | 1 | Read address: 0 configuration, 1 status |
| host_rd_data | output | HOST_DW | Read data (combinational) |
| smp_valid | input | 1 | FIFO holds a word |
| smp_data | input | SAMPLE_W | FIFO head word |
| smp_ready | output | 1 | Pops the head word this cycle |
| dac_bclk | output | 1 | Bit clock to codec |
| dac_lrck | output | 1 | Frame clock, high for left |
| dac_sdata | output | 1 | Serial audio data |

## Verification
Two events can land in the same master-clock cycle: the underrun that a failed channel fetch raises, and a host write that clears the flag. The bench empties its FIFO model and watches smp_ready from the inactive clock edge. When smp_ready is high while smp_valid is low, it drives the clearing write for that same edge, then reads the flag and expects 1. A second clear issued between channel starts must read back 0. A rate write made mid-frame is likewise checked by the high time of every captured bit on both sides of the next frame boundary.

// File: rtl/lj_tx_pkg.sv
package lj_tx_pkg;
   typedef enum logic {
      REG_CFG  = 1'b0,
      REG_STAT = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/lj_cfg_regs.sv
module lj_cfg_regs
   import lj_tx_pkg::*;
#(
   parameter int HOST_DW = 8,
   parameter int RATE_W  = 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_en,
   input  logic               wr_addr,
   input  logic [HOST_DW-1:0] wr_data,
   input  logic               rd_addr,
   output logic [HOST_DW-1:0] rd_data,
   input  logic               underrun_evt,
   output logic               cfg_en,
   output logic [RATE_W-1:0]  cfg_rate,
   output logic               underrun_q,
   output logic               clr_req
);
   logic cfg_wr;
   logic unused_wr_bits;

   assign cfg_wr  = wr_en && (reg_sel_e'(wr_addr) == REG_CFG);
   assign clr_req = wr_en && (reg_sel_e'(wr_addr) == REG_STAT) && wr_data[0];
   assign unused_wr_bits = ^wr_data[HOST_DW-1:RATE_W+1];

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_en   <= 1'b0;
         cfg_rate <= '0;
      end else if (cfg_wr) begin
         cfg_en   <= wr_data[0];
         cfg_rate <= wr_data[RATE_W:1];
      end
   end

   // a fresh underrun outranks a clearing write in the same cycle
   always_ff @(posedge clk) begin
      if (rst)               underrun_q <= 1'b0;
      else if (underrun_evt) underrun_q <= 1'b1;
      else if (clr_req)      underrun_q <= 1'b0;
   end

   always_comb begin
      rd_data = '0;
      if (reg_sel_e'(rd_addr) == REG_CFG) begin
         rd_data[0]        = cfg_en;
         rd_data[RATE_W:1] = cfg_rate;
      end else begin
         rd_data[0] = underrun_q;
      end
   end
endmodule

// File: rtl/lj_bclk_gen.sv
module lj_bclk_gen #(
   parameter int NUM_RATES = 2,
   parameter int HALF_MIN  = 6,
   parameter int RATE_W    = 1,
   parameter int CNT_W     = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [RATE_W-1:0] rate_code,
   output logic              bclk,
   output logic              run,
   output logic              shift_evt
);
   localparam int HALF_MAX = HALF_MIN << (NUM_RATES - 1);
   localparam logic [CNT_W-1:0] HALF_MAX_C = CNT_W'(HALF_MAX);

   logic [RATE_W-1:0] code_c;
   logic [CNT_W-1:0]  half;
   logic [CNT_W-1:0]  cnt;
   logic              phase_end;

   generate
      if ((1 << RATE_W) == NUM_RATES) begin : g_code_exact
         assign code_c = rate_code;
      end else begin : g_code_clamp
         assign code_c = (rate_code >= RATE_W'(NUM_RATES - 1)) ?
                         RATE_W'(NUM_RATES - 1) : rate_code;
      end
   endgenerate

   assign half      = HALF_MAX_C >> code_c;
   assign phase_end = (cnt == half - CNT_W'(1));
   // first event starts the stream; later events are falling edges
   assign shift_evt = en && (!run || (phase_end && bclk));

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         cnt  <= '0;
         bclk <= 1'b0;
         run  <= 1'b0;
      end else if (!run) begin
         run <= 1'b1;
         cnt <= '0;
      end else if (phase_end) begin
         cnt  <= '0;
         bclk <= ~bclk;
      end else begin
         cnt <= cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/lj_frame_ser.sv
module lj_frame_ser #(
   parameter int SAMPLE_W = 16,
   parameter int RATE_W   = 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                en,
   input  logic                run,
   input  logic                shift_evt,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_data,
   input  logic [RATE_W-1:0]   cfg_rate,
   output logic                smp_ready,
   output logic                underrun_evt,
   output logic                lrck,
   output logic                sdata,
   output logic [RATE_W-1:0]   act_rate
);
   localparam int FRAME_BITS = 2 * SAMPLE_W;
   localparam int IDX_W      = $clog2(FRAME_BITS);

   logic [IDX_W-1:0]    idx;
   logic [IDX_W-1:0]    idx_inc;
   logic [IDX_W-1:0]    nxt;
   logic [SAMPLE_W-1:0] sh;
   logic [SAMPLE_W-1:0] word;
   logic                chan_start;
   logic                frame_start;

   generate
      if ((1 << IDX_W) == FRAME_BITS) begin : g_wrap_free
         assign idx_inc = idx + IDX_W'(1);
      end else begin : g_wrap_cmp
         assign idx_inc = (idx == IDX_W'(FRAME_BITS - 1)) ? '0 : idx + IDX_W'(1);
      end
   endgenerate

   assign nxt          = run ? idx_inc : '0;
   assign frame_start  = (nxt == '0);
   assign chan_start   = frame_start || (nxt == IDX_W'(SAMPLE_W));
   assign smp_ready    = shift_evt && chan_start;
   assign underrun_evt = smp_ready && !smp_valid;
   assign word         = smp_valid ? smp_data : '0;

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         idx   <= '0;
         sh    <= '0;
         lrck  <= 1'b0;
         sdata <= 1'b0;
      end else if (shift_evt) begin
         idx <= nxt;
         if (chan_start) begin
            lrck  <= frame_start;
            sdata <= word[SAMPLE_W-1];
            sh    <= {word[SAMPLE_W-2:0], 1'b0};
         end else begin
            sdata <= sh[SAMPLE_W-1];
            sh    <= {sh[SAMPLE_W-2:0], 1'b0};
         end
      end
   end

   // rate follows the register while idle, else only at frame start
   always_ff @(posedge clk) begin
      if (rst)                                  act_rate <= '0;
      else if (!run || (shift_evt && frame_start)) act_rate <= cfg_rate;
   end
endmodule

// File: rtl/lj_audio_tx.sv
module lj_audio_tx #(
   parameter int SAMPLE_W  = 16,
   parameter int NUM_RATES = 2,
   parameter int HALF_MIN  = 6,
   parameter int HOST_DW   = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                host_wr,
   input  logic                host_wr_addr,
   input  logic [HOST_DW-1:0]  host_wr_data,
   input  logic                host_rd_addr,
   output logic [HOST_DW-1:0]  host_rd_data,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_data,
   output logic                smp_ready,
   output logic                dac_bclk,
   output logic                dac_lrck,
   output logic                dac_sdata
);
   localparam int RATE_W   = (NUM_RATES > 1) ? $clog2(NUM_RATES) : 1;
   localparam int HALF_MAX = HALF_MIN << (NUM_RATES - 1);
   localparam int CNT_W    = $clog2(HALF_MAX + 1);

   generate
      if (SAMPLE_W < 2) begin : g_bad_width
         $error("SAMPLE_W must be at least 2");
      end
      if (NUM_RATES < 2) begin : g_bad_rates
         $error("NUM_RATES must be at least 2");
      end
      if (HALF_MIN < 1) begin : g_bad_half
         $error("HALF_MIN must be at least 1");
      end
      if (HOST_DW < RATE_W + 2) begin : g_bad_host
         $error("HOST_DW too narrow for the configuration fields");
      end
   endgenerate

   logic              cfg_en;
   logic [RATE_W-1:0] cfg_rate;
   logic [RATE_W-1:0] act_rate;
   logic              underrun_q;
   logic              underrun_evt;
   logic              clr_req;
   logic              gen_run;
   logic              shift_evt;

   lj_cfg_regs #(.HOST_DW(HOST_DW), .RATE_W(RATE_W)) regs_i (
      .clk          (clk),
      .rst          (rst),
      .wr_en        (host_wr),
      .wr_addr      (host_wr_addr),
      .wr_data      (host_wr_data),
      .rd_addr      (host_rd_addr),
      .rd_data      (host_rd_data),
      .underrun_evt (underrun_evt),
      .cfg_en       (cfg_en),
      .cfg_rate     (cfg_rate),
      .underrun_q   (underrun_q),
      .clr_req      (clr_req)
   );

   lj_bclk_gen #(
      .NUM_RATES (NUM_RATES),
      .HALF_MIN  (HALF_MIN),
      .RATE_W    (RATE_W),
      .CNT_W     (CNT_W)
   ) div_i (
      .clk       (clk),
      .rst       (rst),
      .en        (cfg_en),
      .rate_code (act_rate),
      .bclk      (dac_bclk),
      .run       (gen_run),
      .shift_evt (shift_evt)
   );

   lj_frame_ser #(.SAMPLE_W(SAMPLE_W), .RATE_W(RATE_W)) ser_i (
      .clk          (clk),
      .rst          (rst),
      .en           (cfg_en),
      .run          (gen_run),
      .shift_evt    (shift_evt),
      .smp_valid    (smp_valid),
      .smp_data     (smp_data),
      .cfg_rate     (cfg_rate),
      .smp_ready    (smp_ready),
      .underrun_evt (underrun_evt),
      .lrck         (dac_lrck),
      .sdata        (dac_sdata),
      .act_rate     (act_rate)
   );
endmodule

// File: rtl/lj_audio_tx_chk.sv
module lj_audio_tx_chk (
   input logic clk,
   input logic rst,
   input logic cfg_en,
   input logic gen_run,
   input logic dac_bclk,
   input logic dac_lrck,
   input logic dac_sdata,
   input logic smp_ready,
   input logic smp_valid,
   input logic underrun_q,
   input logic clr_req
);
   AST_IDLE_OUTPUTS_LOW: assert property (@(posedge clk) disable iff (rst)
      !cfg_en |=> (!dac_bclk && !dac_lrck && !dac_sdata)); // R2

   AST_IDLE_NO_POP: assert property (@(posedge clk) disable iff (rst)
      !cfg_en |-> !smp_ready); // R2

   AST_EDGE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      (gen_run && $past(gen_run) && !$stable({dac_lrck, dac_sdata}))
      |-> $fell(dac_bclk)); // R6

   AST_POP_AT_FALL: assert property (@(posedge clk) disable iff (rst)
      (smp_ready && gen_run) |-> dac_bclk); // R7

   AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
      (underrun_q && !clr_req) |=> underrun_q); // R8

   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (smp_ready && !smp_valid) |=> underrun_q); // R9
endmodule

bind lj_audio_tx lj_audio_tx_chk chk_i (
   .clk        (clk),
   .rst        (rst),
   .cfg_en     (cfg_en),
   .gen_run    (gen_run),
   .dac_bclk   (dac_bclk),
   .dac_lrck   (dac_lrck),
   .dac_sdata  (dac_sdata),
   .smp_ready  (smp_ready),
   .smp_valid  (smp_valid),
   .underrun_q (underrun_q),
   .clr_req    (clr_req)
);

// File: tb/lj_audio_tx_tb_top.sv
module lj_audio_tx_tb_top;
   localparam int SW  = 8;
   localparam int NR  = 2;
   localparam int HM  = 2;
   localparam int HDW = 8;
   localparam int HMAX = HM << (NR - 1);

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           host_wr = 1'b0;
   logic           host_wr_addr = 1'b0;
   logic [HDW-1:0] host_wr_data = '0;
   logic           host_rd_addr = 1'b0;
   logic [HDW-1:0] host_rd_data;
   logic           smp_valid;
   logic [SW-1:0]  smp_data;
   logic           smp_ready;
   logic           dac_bclk, dac_lrck, dac_sdata;

   always #5 clk = ~clk;

   lj_audio_tx #(.SAMPLE_W(SW), .NUM_RATES(NR), .HALF_MIN(HM), .HOST_DW(HDW)) dut_i (
      .clk(clk), .rst(rst), .host_wr(host_wr), .host_wr_addr(host_wr_addr),
      .host_wr_data(host_wr_data), .host_rd_addr(host_rd_addr),
      .host_rd_data(host_rd_data), .smp_valid(smp_valid), .smp_data(smp_data),
      .smp_ready(smp_ready), .dac_bclk(dac_bclk), .dac_lrck(dac_lrck),
      .dac_sdata(dac_sdata));

   // FIFO model
   logic [SW-1:0] mem [0:255];
   int  wr_cnt = 0;
   int  rd_ptr = 0;
   logic fifo_clr = 1'b0;
   assign smp_valid = (rd_ptr < wr_cnt);
   assign smp_data  = mem[rd_ptr[7:0]];
   always @(posedge clk) begin
      if (fifo_clr) rd_ptr <= 0;
      else if (smp_ready && smp_valid) rd_ptr <= rd_ptr + 1;
   end

   // line monitor
   logic mon_clr = 1'b0;
   logic pb = 1'b0, pl = 1'b0, pd = 1'b0;
   int   run_len = 0;
   int   nrise = 0, nfs = 0, ncap = 0, viol = 0;
   int   nb = 0;
   logic cur_lr = 1'b0, last_rise_lr = 1'b0;
   logic [31:0] sh = '0;
   int   bit_h [0:1023];
   int   bit_l [0:1023];
   int   fs    [0:255];
   logic cap_lr [0:255];
   logic [31:0] cap_w [0:255];
   int   cap_n [0:255];

   always @(negedge clk) begin
      if (mon_clr) begin
         nrise = 0; nfs = 0; ncap = 0; viol = 0; nb = 0; sh = '0;
         last_rise_lr = 1'b0; run_len = 0;
      end else begin
         if ((dac_lrck != pl || dac_sdata != pd) && dac_bclk) viol++;
         if (dac_bclk && !pb) begin
            if (nrise < 1024) bit_l[nrise] = run_len;
            if (nb > 0 && dac_lrck != cur_lr && ncap < 256) begin
               cap_lr[ncap] = cur_lr; cap_w[ncap] = sh; cap_n[ncap] = nb; ncap++;
               nb = 0; sh = '0;
            end
            cur_lr = dac_lrck;
            sh = {sh[30:0], dac_sdata};
            nb++;
            if (dac_lrck && !last_rise_lr && nfs < 256) begin fs[nfs] = nrise; nfs++; end
            last_rise_lr = dac_lrck;
            nrise++;
         end
         if (!dac_bclk && pb && nrise > 0 && nrise <= 1024) bit_h[nrise-1] = run_len;
         if (dac_bclk != pb) run_len = 1; else run_len++;
      end
      pb = dac_bclk; pl = dac_lrck; pd = dac_sdata;
   end

   int nchk = 0, nerr = 0;
   logic done = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // caller stands at a negedge
   task automatic hwrite(input logic a, input logic [HDW-1:0] d);
      host_wr = 1'b1; host_wr_addr = a; host_wr_data = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hread(input logic a, output logic [HDW-1:0] d);
      host_rd_addr = a; #1; d = host_rd_data;
   endtask

   task automatic pulse_clr();
      @(negedge clk); fifo_clr = 1'b1; mon_clr = 1'b1;
      @(negedge clk); @(negedge clk); fifo_clr = 1'b0; mon_clr = 1'b0;
   endtask

   function automatic logic [SW-1:0] pat(input int p, input int i, input int c);
      case (p)
         0: pat = SW'(i * 29 + c * 7 + 3);
         1: pat = (i % 2 == 1) ? SW'(8'h5A) : SW'(8'hA5);
         2: pat = SW'(1) << (i % SW);
         default: pat = (i % 2 == 1) ? SW'(1) << (SW - 1) : '1;
      endcase
   endfunction

   initial begin
      logic [HDW-1:0] rd;
      int half, fpc, nfs_w, f1;
      repeat (5) @(negedge clk);
      chk("R1 bclk", dac_bclk, 0);
      chk("R1 lrck", dac_lrck, 0);
      chk("R1 sdata", dac_sdata, 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 ready", smp_ready, 0);
      hread(1'b0, rd); chk("R1 cfg", rd, 0);
      hread(1'b1, rd); chk("R1 status", rd, 0);

      // R2: disabled with data waiting
      for (int i = 0; i < 8; i++) mem[i] = pat(0, i, 0);
      wr_cnt = 8;
      pulse_clr();
      hwrite(1'b0, 8'h02);
      repeat (100) @(negedge clk);
      chk("R2 no bclk edges", nrise, 0);
      chk("R2 no pops", rd_ptr, 0);
      chk("R2 lines low", {dac_bclk, dac_lrck, dac_sdata}, 0);
      hread(1'b0, rd); chk("R3 cfg readback", rd, 8'h02);

      // R3..R7 sweep over rate codes and patterns
      for (int c = 0; c < NR; c++) begin
         for (int p = 0; p < 4; p++) begin
            half = HMAX >> c;
            fpc  = 2 * SW * 2 * half;
            hwrite(1'b0, 8'h00);
            repeat (4) @(negedge clk);
            for (int i = 0; i < 12; i++) mem[i] = pat(p, i, c);
            wr_cnt = 12;
            pulse_clr();
            hwrite(1'b0, HDW'((c << 1) | 1));
            repeat (4 * fpc + 10) @(negedge clk);
            chk("R6 edge alignment", viol, 0);
            chk("R4 frame length", fs[1] - fs[0], 2 * SW);
            chk("R3 high phase", bit_h[3], half);
            chk("R3 low phase", bit_l[5], half);
            for (int h = 0; h < 6; h++) begin
               chk("R5 channel level", cap_lr[h], (h % 2 == 0));
               chk("R4 bits per channel", cap_n[h], SW);
               chk("R7 word order", cap_w[h], 32'(mem[h]));
            end
         end
      end

      // R8/R9 underrun
      hwrite(1'b0, 8'h00);
      repeat (4) @(negedge clk);
      for (int i = 0; i < 3; i++) mem[i] = pat(0, i + 40, 1);
      wr_cnt = 3;
      pulse_clr();
      hwrite(1'b1, 8'h01);
      hread(1'b1, rd); chk("R9 clear while idle", rd, 0);
      hwrite(1'b0, 8'h03);
      repeat (3 * 2 * SW * 2 * HM + 10) @(negedge clk);
      for (int h = 0; h < 3; h++) chk("R8 data before empty", cap_w[h], 32'(mem[h]));
      chk("R8 zero word", cap_w[3], 0);
      chk("R8 zero word", cap_w[4], 0);
      chk("R8 channel bits", cap_n[4], SW);
      hread(1'b1, rd); chk("R8 sticky flag", rd, 1);
      while (!smp_ready) @(negedge clk);
      @(negedge clk);
      hwrite(1'b1, 8'h01);
      hread(1'b1, rd); chk("R9 clear", rd, 0);
      while (!smp_ready) @(negedge clk);
      hwrite(1'b1, 8'h01);
      hread(1'b1, rd); chk("R9 set beats clear", rd, 1);
      hwrite(1'b0, 8'h00);
      hwrite(1'b1, 8'h01);
      hread(1'b1, rd); chk("R9 clear after stop", rd, 0);

      // R10 rate change mid-frame
      repeat (4) @(negedge clk);
      for (int i = 0; i < 16; i++) mem[i] = pat(0, i + 60, 0);
      wr_cnt = 16;
      pulse_clr();
      hwrite(1'b0, 8'h01);
      while (nfs < 2) @(negedge clk);
      repeat (40) @(negedge clk);
      nfs_w = nfs;
      hwrite(1'b0, 8'h03);
      repeat (4 * 2 * SW * 2 * HM) @(negedge clk);
      f1 = fs[nfs_w];
      chk("R10 old frame full length", f1 - fs[nfs_w - 1], 2 * SW);
      chk("R10 old rate to boundary", bit_h[f1 - 1], HMAX);
      chk("R10 new rate at boundary", bit_h[f1], HM);
      chk("R10 new rate whole frame", bit_h[f1 + 2 * SW - 1], HM);
      chk("R10 new frame length", fs[nfs_w + 1] - f1, 2 * SW);
      for (int h = 0; h < 8; h++) chk("R10 data continuity", cap_w[h], 32'(mem[h]));
      chk("R6 edge alignment across switch", viol, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end
endmodule